// File: doc/BRIEF.md
# Event Counter Bank with Per-Counter Interrupts

This block holds eight event counters that software reaches through a small word-addressed register interface. Every counter watches one line of a vector of single-cycle event strobes. A byte-wide select code chooses the line for each counter. Counting runs only while one global enable bit in the control word is set. A counter is readable and writable at any time, so software can preload it.

To sample every N events, software writes the two's complement of N into a counter. After exactly N selected events the counter passes all-ones and returns to zero. The wrap latches a sticky overflow flag in the control word. The counter's own interrupt line is high while that flag is set and the counter's interrupt enable is set. Software clears a flag by writing a one to its bit, and zeros written to flag bits leave the flags alone. Which processor takes each interrupt, and what each event strobe means, are decided outside the block.

Top module: `evmon_bank`

## Requirements
- R1: After reset, every counter, every select code, the global enable, all interrupt enables and all overflow flags are zero, and all eight interrupt outputs are low.
- R2: Counter i is read and written at word index 3+i, so indices 3 to 10 cover counters 0 to 7. When a write to a counter and an increment of that counter fall in the same cycle, the written value is stored and no increment or wrap happens in that cycle.
- R3: A counter with select code c adds one in a cycle when the global enable is 1, c is nonzero, c is below EVENT_COUNT and eventIn[c] is high. Code 0 and codes of EVENT_COUNT or more never count. The line eventIn[0] is never selected.
- R4: Word index 1 holds the select codes of counters 0 to 3, with counter j in bits [8j+7:8j]. Word index 2 holds those of counters 4 to 7 in the same order. Both words read back as written.
- R5: The global enable is control word (index 0) bit 0. While it is 0, no counter changes except by a write.
- R6: On an increment from all-ones a counter becomes zero and its overflow flag, control bit 16+i, is set.
- R7: Writing 1 to control bit 16+i clears that flag, and writing 0 leaves it unchanged. If a wrap and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: irqOut[i] is high exactly while flag i is set and interrupt enable i (control bit 8+i) is 1. Clearing an interrupt enable does not stop any counter and does not change the global enable or the flags.
- R9: Control bits 1 to 7 and 24 to 31 read as zero. Word indices 11 to 15 read as zero.
- R10: A counter preloaded with the two's complement of N sets its flag on exactly the N-th selected event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe for the word at regSel |
| regSel | input | 4 | Word index of the register to read or write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the word at regSel (combinational) |
| eventIn | input | EVENT_COUNT | Event strobes, one per line |
| irqOut | output | 8 | Per-counter interrupt lines |

## Verification
On every cycle the assertions check the counter rules. A counter with code zero or with the global enable off holds its value. A wrap from all-ones yields zero and a set flag. A counter write always lands. A flag stays set unless a clear is strobed, and an interrupt line drops once its flag falls. Other behaviour can only be shown by the bench scenarios. These are the full sweep of select codes against chosen strobe patterns and the register layout with its reserved bits. They also cover the exact event on which each preloaded counter overflows, and the same-cycle races between a write and an increment and between a wrap and a clear.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int NUM_CNT = 8;
  localparam int BUS_W   = 32;
  localparam int SEL_W   = 8;

  typedef struct packed {
    logic [NUM_CNT-1:0] cntWr;
    logic [NUM_CNT-1:0] cntInc;
    logic [NUM_CNT-1:0] ovfClr;
    logic [BUS_W-1:0]   wrData;
  } ctlStrobes_t;
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter
  import evmon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             incEn,
  input  logic             clrFlag,
  input  logic [CNT_W-1:0] wrVal,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic wrapNow;

  assign wrapNow = incEn && !wrEn && (count == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (wrEn) begin
      count <= wrVal;
    end else if (incEn) begin
      count <= count + 1'b1;
    end
  end

  // set has priority over a simultaneous software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovf <= 1'b0;
    end else if (wrapNow) begin
      ovf <= 1'b1;
    end else if (clrFlag) begin
      ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/evmon_datapath.sv
module evmon_datapath
  import evmon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobes_t                   strb,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [NUM_CNT-1:0]            ovfFlag
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    evmon_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (strb.cntWr[i]),
      .incEn   (strb.cntInc[i]),
      .clrFlag (strb.ovfClr[i]),
      .wrVal   (strb.wrData[CNT_W-1:0]),
      .count   (cntVal[i]),
      .ovf     (ovfFlag[i])
    );
  end
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int EVENT_COUNT = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWrEn,
  input  logic [3:0]                    regSel,
  input  logic [BUS_W-1:0]              busWrData,
  output logic [BUS_W-1:0]              busRdData,
  input  logic [EVENT_COUNT-1:0]        eventIn,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input  logic [NUM_CNT-1:0]            ovfFlag,
  output ctlStrobes_t                   strb,
  output logic                          globalEn,
  output logic [NUM_CNT-1:0]            intEn,
  output logic [NUM_CNT-1:0][SEL_W-1:0] selCode,
  output logic [NUM_CNT-1:0]            irqOut
);
  localparam int HALF     = NUM_CNT / 2;
  localparam int IE_LSB   = 8;
  localparam int OVF_LSB  = 16;
  localparam int CNT_BASE = 3;

  logic ctrlHit;
  logic selLoHit;
  logic selHiHit;

  assign ctrlHit  = busWrEn && (regSel == 4'd0);
  assign selLoHit = busWrEn && (regSel == 4'd1);
  assign selHiHit = busWrEn && (regSel == 4'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      intEn    <= '0;
    end else if (ctrlHit) begin
      globalEn <= busWrData[0];
      intEn    <= busWrData[IE_LSB +: NUM_CNT];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    localparam int BYTE_POS = (i % HALF) * SEL_W;
    logic selWrite;
    logic codeValid;
    logic lineHit;

    if (i < HALF) begin : g_lo
      assign selWrite = selLoHit;
    end else begin : g_hi
      assign selWrite = selHiHit;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selCode[i] <= '0;
      end else if (selWrite) begin
        selCode[i] <= busWrData[BYTE_POS +: SEL_W];
      end
    end

    assign codeValid = (selCode[i] != '0) && (int'(selCode[i]) < EVENT_COUNT);

    always_comb begin
      lineHit = 1'b0;
      for (int e = 1; e < EVENT_COUNT; e++) begin
        if (int'(selCode[i]) == e) begin
          lineHit = eventIn[e];
        end
      end
    end

    assign strb.cntInc[i] = globalEn && codeValid && lineHit;
    assign strb.cntWr[i]  = busWrEn && (int'(regSel) == CNT_BASE + i);
  end

  assign strb.ovfClr = ctrlHit ? busWrData[OVF_LSB +: NUM_CNT] : '0;
  assign strb.wrData = busWrData;
  assign irqOut      = ovfFlag & intEn;

  always_comb begin
    busRdData = '0;
    case (regSel)
      4'd0: begin
        busRdData[0]                  = globalEn;
        busRdData[IE_LSB +: NUM_CNT]  = intEn;
        busRdData[OVF_LSB +: NUM_CNT] = ovfFlag;
      end
      4'd1: begin
        for (int j = 0; j < HALF; j++) busRdData[j*SEL_W +: SEL_W] = selCode[j];
      end
      4'd2: begin
        for (int j = 0; j < HALF; j++) busRdData[j*SEL_W +: SEL_W] = selCode[HALF + j];
      end
      default: begin
        for (int j = 0; j < NUM_CNT; j++) begin
          if (int'(regSel) == CNT_BASE + j) busRdData[CNT_W-1:0] = cntVal[j];
        end
      end
    endcase
  end
endmodule

// File: rtl/evmon_bank.sv
module evmon_bank
  import evmon_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int EVENT_COUNT = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWrEn,
  input  logic [3:0]             regSel,
  input  logic [BUS_W-1:0]       busWrData,
  output logic [BUS_W-1:0]       busRdData,
  input  logic [EVENT_COUNT-1:0] eventIn,
  output logic [NUM_CNT-1:0]     irqOut
);
  ctlStrobes_t                   strb;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CNT-1:0]            ovfFlag;
  logic                          globalEn;
  logic [NUM_CNT-1:0]            intEn;
  logic [NUM_CNT-1:0][SEL_W-1:0] selCode;

  evmon_ctrl #(.CNT_W(CNT_W), .EVENT_COUNT(EVENT_COUNT)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .regSel    (regSel),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .eventIn   (eventIn),
    .cntVal    (cntVal),
    .ovfFlag   (ovfFlag),
    .strb      (strb),
    .globalEn  (globalEn),
    .intEn     (intEn),
    .selCode   (selCode),
    .irqOut    (irqOut)
  );

  evmon_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cntVal  (cntVal),
    .ovfFlag (ovfFlag)
  );
endmodule

// File: rtl/evmon_bank_chk.sv
module evmon_bank_chk
  import evmon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input ctlStrobes_t                   strb,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input logic [NUM_CNT-1:0]            ovfFlag,
  input logic                          globalEn,
  input logic [NUM_CNT-1:0]            intEn,
  input logic [NUM_CNT-1:0][SEL_W-1:0] selCode,
  input logic [NUM_CNT-1:0]            irqOut
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    p_idle_code_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
      (selCode[i] == '0 && !strb.cntWr[i]) |=> $stable(cntVal[i]));

    p_global_off_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!globalEn && !strb.cntWr[i]) |=> $stable(cntVal[i]));

    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
      (cntVal[i] == '1 && strb.cntInc[i] && !strb.cntWr[i]) |=>
        (ovfFlag[i] && cntVal[i] == '0));

    p_write_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
      strb.cntWr[i] |=> (cntVal[i] == $past(strb.wrData[CNT_W-1:0])));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlag[i] && !strb.ovfClr[i]) |=> ovfFlag[i]);

    p_irq_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ovfFlag[i]) |-> !irqOut[i]);

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
      $fell(intEn[i]) |-> !irqOut[i]);
  end
endmodule

bind evmon_bank evmon_bank_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .cntVal   (cntVal),
  .ovfFlag  (ovfFlag),
  .globalEn (globalEn),
  .intEn    (intEn),
  .selCode  (selCode),
  .irqOut   (irqOut)
);

// File: tb/evmon_bank_tb_top.sv
`timescale 1ns/1ps
module evmon_bank_tb_top;
  localparam int EVN = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  regSel = 4'd0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [EVN-1:0] eventIn = '0;
  logic [7:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evmon_bank #(.CNT_W(32), .EVENT_COUNT(EVN)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .regSel(regSel),
    .busWrData(busWrData), .busRdData(busRdData),
    .eventIn(eventIn), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; regSel = idx; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] idx, output logic [31:0] data);
    regSel = idx;
    #1;
    data = busRdData;
  endtask

  task automatic pulse(input logic [EVN-1:0] ev, input int n);
    for (int k = 0; k < n; k++) begin
      eventIn = ev;
      @(negedge clk);
    end
    eventIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  fl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int w = 0; w < 11; w++) begin
      rdReg(4'(w), v);
      chk("R1 reset word", v, 32'h0);
    end
    chk("R1 reset irq", {24'h0, irqOut}, 32'h0);

    // R2 counter read/write
    for (int i = 0; i < 8; i++) wrReg(4'(3 + i), 32'hA5A5_0000 ^ (32'h1111_1111 * i));
    for (int i = 0; i < 8; i++) begin
      rdReg(4'(3 + i), v);
      chk("R2 counter readback", v, 32'hA5A5_0000 ^ (32'h1111_1111 * i));
    end

    // R4 select layout
    wrReg(4'd1, 32'h0403_0201);
    wrReg(4'd2, 32'h0807_0605);
    rdReg(4'd1, v); chk("R4 select low word", v, 32'h0403_0201);
    rdReg(4'd2, v); chk("R4 select high word", v, 32'h0807_0605);

    // R9 reserved and unmapped
    for (int w = 11; w < 16; w++) begin
      rdReg(4'(w), v);
      chk("R9 unmapped word", v, 32'h0);
    end
    wrReg(4'd0, 32'hFFFF_FFFF);
    rdReg(4'd0, v); chk("R9 reserved control bits", v, 32'h0000_FF01);
    wrReg(4'd0, 32'h0);

    // R3 sweep of select codes on counter 0
    for (int c = 0; c < 20; c++) begin
      logic [EVN-1:0] own;
      int expc;
      own = (c < EVN) ? (EVN'(1) << c) : '0;
      expc = (c != 0 && c < EVN) ? 3 : 0;
      wrReg(4'd0, 32'h0);
      wrReg(4'd3, 32'h0);
      wrReg(4'd1, 32'(c));
      wrReg(4'd0, 32'h1);
      pulse(own, 3);
      pulse(~own, 2);
      wrReg(4'd0, 32'h0);
      rdReg(4'd3, v);
      chk($sformatf("R3 code %0d count", c), v, 32'(expc));
    end

    // R5 global enable
    wrReg(4'd1, 32'h0101_0101);
    wrReg(4'd2, 32'h0101_0101);
    for (int i = 0; i < 8; i++) wrReg(4'(3 + i), 32'h0);
    pulse(16'h0002, 4);
    for (int i = 0; i < 8; i++) begin
      rdReg(4'(3 + i), v);
      chk("R5 disabled no count", v, 32'h0);
    end
    wrReg(4'd0, 32'h1);
    pulse(16'h0002, 4);
    wrReg(4'd0, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rdReg(4'(3 + i), v);
      chk("R5 enabled count", v, 32'h4);
    end

    // R6 R10 R8: preload -(i+1), step one event at a time
    for (int i = 0; i < 8; i++) wrReg(4'(3 + i), 32'(-(i + 1)));
    wrReg(4'd0, 32'h00FF_0000);
    wrReg(4'd0, 32'h0000_5501);
    for (int k = 1; k <= 9; k++) begin
      eventIn = 16'h0002;
      @(negedge clk);
      fl = (k >= 8) ? 8'hFF : 8'((1 << k) - 1);
      rdReg(4'd0, v);
      chk($sformatf("R10 flags after %0d events", k), v, {8'h0, fl, 8'h55, 8'h01});
      chk("R8 irq lines", {24'h0, irqOut}, {24'h0, fl & 8'h55});
    end
    eventIn = '0;
    for (int i = 0; i < 8; i++) begin
      rdReg(4'(3 + i), v);
      chk("R6 value after wrap", v, 32'(8 - i));
    end

    // R8 clearing an interrupt enable
    wrReg(4'd0, 32'h0000_5401);
    rdReg(4'd0, v); chk("R8 ie clear keeps flags and enable", v, 32'h00FF_5401);
    chk("R8 irq after ie clear", {24'h0, irqOut}, 32'h54);
    pulse(16'h0002, 3);
    rdReg(4'd3, v); chk("R8 counter 0 keeps counting", v, 32'd11);
    rdReg(4'd4, v); chk("R8 counter 1 keeps counting", v, 32'd10);

    // R7 write-one-to-clear
    wrReg(4'd0, 32'h000F_5401);
    rdReg(4'd0, v); chk("R7 clear low flags", v, 32'h00F0_5401);
    chk("R7 irq after clear", {24'h0, irqOut}, 32'h50);

    // R7 wrap and clear in the same cycle: flag stays
    wrReg(4'd5, 32'hFFFF_FFFF);
    @(negedge clk);
    busWrEn = 1'b1; regSel = 4'd0; busWrData = 32'h0004_5401; eventIn = 16'h0002;
    @(negedge clk);
    busWrEn = 1'b0; eventIn = '0;
    rdReg(4'd0, v); chk("R7 set beats clear", v, 32'h00F4_5401);
    rdReg(4'd5, v); chk("R6 counter 2 wrapped", v, 32'h0);
    chk("R8 irq counter 2", {24'h0, irqOut}, 32'h54);

    // R2 write beats increment on all-ones
    wrReg(4'd6, 32'hFFFF_FFFF);
    @(negedge clk);
    busWrEn = 1'b1; regSel = 4'd6; busWrData = 32'h0000_0055; eventIn = 16'h0002;
    @(negedge clk);
    busWrEn = 1'b0; eventIn = '0;
    rdReg(4'd6, v); chk("R2 write wins", v, 32'h55);
    rdReg(4'd0, v); chk("R2 no wrap on write", v, 32'h00F4_5401);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule